// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is a small, fast storage array for a processor datapath. It holds thirty-two words of thirty-two bits. Two read ports look up any two words in the same cycle and return them without a clock edge in between. One write port stores a word into the selected entry on the falling edge of the clock, so a value written in the second half of a cycle can be read back in the next cycle. Entry zero is a constant: it reads as zero and ignores any write.

A pipeline uses it as follows. The two source operands are read through the read ports from their index inputs. The result is written back through the write port with the write enable raised for that cycle. A synchronous active-low reset clears every entry to zero on a falling edge. It gives simulation and bring-up a known starting state.

Top module: `regfile_2r1w`

## Requirements
- R1: When `wr_en` is 1 and `wr_idx` is nonzero at a falling clock edge, the entry selected by `wr_idx` takes `wr_data`, and both read ports return that value afterwards when they select that index.
- R2: A read of an entry during the cycle in which it is written returns the old contents until the falling edge, and the new contents after it.
- R3: Index 0 always reads as zero on both ports, and a write with `wr_idx` equal to 0 has no effect on any entry.
- R4: When `wr_en` is 0 at a falling edge, no entry changes, whatever the values on `wr_idx` and `wr_data`.
- R5: The two read ports are combinational and independent, and they may select the same index; each returns the contents of its own selected entry.
- R6: When `rst_n` is 0 at a falling edge, every entry becomes zero, and a write presented in that cycle is discarded.
- R7: A write changes only the addressed entry; all other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; entries update on its falling edge |
| rst_n | input | 1 | Synchronous active-low clear of all entries |
| wr_en | input | 1 | Write enable, 1 = store `wr_data` |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 32 | Data to store |
| rd_idx_a | input | 5 | Index read on port A |
| rd_idx_b | input | 5 | Index read on port B |
| rd_data_a | output | 32 | Contents of the entry selected by `rd_idx_a` |
| rd_data_b | output | 32 | Contents of the entry selected by `rd_idx_b` |

## Verification
A read and a write of the same entry can fall in one cycle. The stimulus for this case sets a read index equal to the write index with the enable raised. The bench samples both read ports twice in that cycle: once shortly before the falling edge, when the old value is expected, and once just after it, when the new value is expected. Each sample is compared with a bench-side array that is updated only by the write rules. Writes to index 0 and writes with the enable low are included, and both read ports are aimed at the same entry, so that an early, late, stray or dropped update shows up.

// File: rtl/rf_pkg.sv
// Package: defaults shared by the register file and its checker.
// Assumes nothing beyond the parameters below; holds no state.
package rf_pkg;

    // Default number of entries in the file.
    localparam int DEF_NUM_REGS = 32;

    // Default width of one entry in bits.
    localparam int DEF_DATA_W   = 32;

    // Index value reserved for the constant-zero entry.
    localparam int ZERO_IDX     = 0;

endpackage

// File: rtl/rf_wr_decoder.sv
// Write decoder: turns a write index plus enable into one write strobe per
// writable entry. Entry 0 has no strobe, because it is constant zero.
// Assumes NUM_REGS >= 2; at most one strobe is high in any cycle.
module rf_wr_decoder #(
    parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    output logic [NUM_REGS-1:1]   strobe
);

    // One comparator per writable entry, gated by the enable.
    always_comb begin
        for (int i = 1; i < NUM_REGS; i++) begin
            strobe[i] = en && (idx == IDX_W'(i));
        end
    end

endmodule

// File: rtl/rf_storage.sv
// Storage array: one word-wide register per writable entry, updated on the
// falling clock edge. Entry 0 is a wired zero with no flops behind it.
// Assumes strobes are one-hot or zero; reset is synchronous, active low.
module rf_storage #(
    parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::DEF_DATA_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:1]              strobe,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  words
);

    // Constant-zero entry: no storage, no write path.
    assign words[rf_pkg::ZERO_IDX] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_entry
        logic [DATA_W-1:0] q;

        // Falling-edge update: clear on reset, else load when strobed.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (strobe[i]) begin
                q <= wdata;
            end
        end

        assign words[i] = q;
    end

endmodule

// File: rtl/rf_read_mux.sv
// Read multiplexer: returns the word selected by an index, with no clock.
// Assumes the index is below NUM_REGS; any other value returns zero.
module rf_read_mux #(
    parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::DEF_DATA_W,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  words,
    input  logic [IDX_W-1:0]                 idx,
    output logic [DATA_W-1:0]                data
);

    // Select one word by index; entry 0 and unused codes give zero.
    always_comb begin
        data = '0;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                data = words[i];
            end
        end
    end

endmodule

// File: rtl/regfile_2r1w.sv
// Register file with two combinational read ports and one write port.
// The write lands on the falling clock edge; entry 0 reads as zero.
// Assumes the write index is stable around the falling edge.
module regfile_2r1w #(
    parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::DEF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:1]             strobe;
    logic [NUM_REGS-1:0][DATA_W-1:0] words;
    logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

    rf_wr_decoder #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_dec (
        .en     (wr_en),
        .idx    (wr_idx),
        .strobe (strobe)
    );

    rf_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .wdata  (wr_data),
        .words  (words)
    );

    // Gather the port indices so the read muxes come from one loop.
    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_mux #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .IDX_W    (IDX_W)
        ) u_mux (
            .words (words),
            .idx   (rd_idx[p]),
            .data  (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

endmodule

// File: rtl/regfile_2r1w_chk.sv
// Checker: port-level properties of the register file, bound to its top.
// All properties are sampled on the falling edge, where writes land.
module regfile_2r1w_chk #(
    parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::DEF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [IDX_W-1:0]  rd_idx_a,
    input logic [IDX_W-1:0]  rd_idx_b,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);

    // R3: index 0 reads zero on port A.
    p_zero_a_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_idx_a == '0) |-> (rd_data_a == '0));

    // R3: index 0 reads zero on port B.
    p_zero_b_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_idx_b == '0) |-> (rd_data_b == '0));

    // R1: a write to a nonzero entry is seen on port A one edge later.
    p_write_seen_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0) && (rd_idx_a == wr_idx)) ##1 $stable(rd_idx_a)
        |-> (rd_data_a == $past(wr_data)));

    // R4: with the enable low, a held read index sees a held value.
    p_no_we_hold_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (!wr_en) ##1 $stable(rd_idx_b) |-> $stable(rd_data_b));

    // R5: both ports on one index return the same word.
    p_same_idx_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));

endmodule

bind regfile_2r1w regfile_2r1w_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/regfile_2r1w_tb.sv
// Bench: vector table walk, then directed sweeps and corner cases.
module regfile_2r1w_tb;

    localparam int NREG = 32;
    localparam int DW   = 32;
    localparam int IW   = 5;
    localparam int VW   = 1 + IW + DW + IW + IW;
    localparam int NVEC = 14;

    // Vector layout: {we, write index, write data, read index A, read index B}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b1, 5'd5,  32'hDEAD_BEEF, 5'd5,  5'd0 },
        {1'b1, 5'd6,  32'h1234_5678, 5'd5,  5'd6 },
        {1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0 },
        {1'b0, 5'd5,  32'h0BAD_0BAD, 5'd5,  5'd5 },
        {1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd30},
        {1'b1, 5'd30, 32'h7FFF_FFFE, 5'd31, 5'd30},
        {1'b1, 5'd5,  32'hCAFE_F00D, 5'd6,  5'd5 },
        {1'b0, 5'd0,  32'h5555_5555, 5'd0,  5'd6 },
        {1'b1, 5'd1,  32'hAAAA_AAAA, 5'd1,  5'd1 },
        {1'b1, 5'd1,  32'h0000_0000, 5'd1,  5'd2 },
        {1'b1, 5'd2,  32'hFFFF_FFFF, 5'd1,  5'd2 },
        {1'b0, 5'd2,  32'h0000_0000, 5'd2,  5'd31},
        {1'b1, 5'd16, 32'h0F0F_F0F0, 5'd15, 5'd16},
        {1'b1, 5'd15, 32'hF0F0_0F0F, 5'd15, 5'd16}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic [IW-1:0] rd_idx_a;
    logic [IW-1:0] rd_idx_b;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    int checks   = 0;
    int failures = 0;
    logic [DW-1:0] model [NREG];

    always #5 clk = ~clk;

    regfile_2r1w u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive after the rising edge, sample before and after the falling edge.
    task automatic cycle(input logic we_i, input int rw, input logic [DW-1:0] wd,
                         input int ra, input int rb, input string tag);
        @(posedge clk); #1;
        wr_en = we_i; wr_idx = IW'(rw); wr_data = wd;
        rd_idx_a = IW'(ra); rd_idx_b = IW'(rb);
        #2;
        check({tag, " pre A"}, rd_data_a, model[ra]);
        check({tag, " pre B"}, rd_data_b, model[rb]);
        @(negedge clk); #1;
        if (rst_n && we_i && rw != 0) model[rw] = wd;
        check({tag, " post A"}, rd_data_a, model[ra]);
        check({tag, " post B"}, rd_data_b, model[rb]);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; wr_en = 1'b1; wr_idx = IW'(9); wr_data = 32'h9999_9999;
        @(negedge clk); #1;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        @(posedge clk); #1;
        rst_n = 1'b1; wr_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        rd_idx_a = '0; rd_idx_b = '0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        do_reset();

        // R6: every entry reads zero after reset on both ports
        for (int i = 0; i < NREG; i++) begin
            cycle(1'b0, 0, '0, i, NREG - 1 - i, "R6 reset state");
        end

        // R1/R2/R3/R4/R5: table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            cycle(e[VW-1], int'(e[VW-2 -: IW]), e[DW+2*IW-1 -: DW],
                  int'(e[2*IW-1 -: IW]), int'(e[IW-1:0]), "R1/R2/R3/R4/R5 vector");
        end

        // R1/R2: write each entry while reading it on port A; R7: neighbours on port B
        for (int i = 0; i < NREG; i++) begin
            cycle(1'b1, i, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101), i, (i + 1) % NREG,
                  "R1/R2/R7 sweep");
        end

        // R5/R7: read back all entries on both ports, same and mirrored indices
        for (int i = 0; i < NREG; i++) begin
            cycle(1'b0, 0, '0, i, i, "R5 same index");
            cycle(1'b0, 0, '0, i, NREG - 1 - i, "R5/R7 mirrored");
        end

        // R3: write to entry 0 with all ones, then read it
        cycle(1'b1, 0, 32'hFFFF_FFFF, 0, 0, "R3 write zero");
        cycle(1'b0, 0, '0, 0, 0, "R3 read zero");

        // R4: enable low over every index leaves contents intact
        for (int i = 0; i < NREG; i++) begin
            cycle(1'b0, i, 32'h1357_9BDF, i, i, "R4 no enable");
        end

        // R6: reset mid-run with a write pending discards the write and clears all
        do_reset();
        for (int i = 0; i < NREG; i++) begin
            cycle(1'b0, 0, '0, i, (i + 9) % NREG, "R6 mid-run reset");
        end

        // R2: back-to-back writes to one entry seen on the falling edge each time
        cycle(1'b1, 12, 32'h0000_0001, 12, 12, "R2 back-to-back 1");
        cycle(1'b1, 12, 32'h0000_0002, 12, 12, "R2 back-to-back 2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule